// File: doc/BRIEF.md
# High-Memory RAM Overlay Controller

This block steers the top twelve kilobyte-pages of a 64 KB processor address map (pages 0xD0 through 0xFF) between the fixed ROM and a 16 KB RAM overlay. Software drives it by touching addresses in a sixteen-entry switch window at I/O offsets 0x80–0x8F. The low address bits of each touch pick the overlay bank for pages 0xD0–0xDF, whether reads come from RAM or from ROM, and whether writes reach RAM at all. An alternate-zero-page input picks between a main and an auxiliary copy of the whole overlay.

Writes to the overlay are armed by an internal pre-write latch. Only two reads in a row of an odd-numbered switch open the RAM for writing. A write to such a switch disarms the latch, so a single read-modify-write cannot unlock the overlay by accident. The read source and the write target are reported separately for the page on the `cpu_page` input. A read-only status pair reports the selected bank and the read source. The RAM arrays are not part of this block.

Every pin is a plain control or status signal. There is no data stream, so there is no valid/ready handshake. A switch access is a single-cycle strobe (`io_strobe`) that is sampled at the rising clock edge. The status reply is combinational while the strobe is high.

Top module: `hiram_overlay_ctrl`

## Requirements
- R1: An access to a switch offset (0x80–0x8F) with bit 0 clear clears write-enable and the pre-write latch. RAM read is then on when bit 1 is 0 (0x80, 0x88) and off when bit 1 is 1 (0x82, 0x8A).
- R2: An access to a switch offset with bit 0 set turns RAM read on when bit 1 is 1 (0x83, 0x8B) and off when bit 1 is 0 (0x81, 0x89).
- R3: A read of an odd switch first copies the pre-write latch into write-enable and then sets the latch. Two consecutive odd-switch reads therefore enable writes, and one read alone does not.
- R4: A write to an odd switch clears the pre-write latch and leaves write-enable as it was. A read, a write and a read of an odd switch, starting from the disabled state, leave writes disabled.
- R5: Every switch access loads the bank select from bit 3 of the offset: 1 selects bank 1 and 0 selects bank 2.
- R6: When the path (read or write) is enabled, pages 0xD0–0xDF map to target 1 for bank 1 main, 2 for bank 1 aux, 3 for bank 2 main and 4 for bank 2 aux. Aux is chosen when `alt_zp` is 1.
- R7: When the path is enabled, pages 0xE0–0xFF map to target 1 (main) or 2 (aux), whatever the bank select.
- R8: The read target and the write target are decided independently. A disabled path reports target 0 (ROM), and a write sent to ROM is discarded.
- R9: A read of offset 0x11 returns 0x80 when bank 2 is selected and 0x00 otherwise. A read of 0x12 returns 0x80 when RAM read is on. A read of any switch offset returns 0x00. For all three, `io_rvalid` is 1.
- R10: After reset, bank 2 is selected, RAM read is off, write-enable is off and the pre-write latch is clear.
- R11: Accesses to offsets outside 0x80–0x8F leave all overlay state unchanged.
- R12: For pages below 0xD0, `in_overlay` is 0 and both targets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_strobe | input | 1 | One-cycle I/O access strobe |
| io_offset | input | 8 | Offset inside the I/O page |
| io_write | input | 1 | 1 = write access, 0 = read access |
| alt_zp | input | 1 | Selects the auxiliary overlay copy |
| cpu_page | input | 8 | Address page to be mapped |
| io_rdata | output | 8 | Status/switch read data |
| io_rvalid | output | 1 | This block answers the current read |
| in_overlay | output | 1 | `cpu_page` is in 0xD0–0xFF |
| rd_target | output | 3 | Read source: 0 ROM, 1–4 RAM copy |
| wr_target | output | 3 | Write target: 0 ROM (discarded), 1–4 RAM copy |

## Verification
An odd-switch read does two things at the same clock edge: it copies the old pre-write latch into write-enable, and it arms the latch for the next access. The bench provokes this with back-to-back reads of 0x81, 0x83 and 0x8B. It checks that the write target stays ROM after the first read and turns to RAM only after the second. It also places a write between two reads, and judges from `wr_target` that the arming was undone in the same cycle that the copy was skipped.

// File: rtl/hiram_pkg.sv
package hiram_pkg;
  typedef enum logic [2:0] {
    TGT_ROM     = 3'd0,
    TGT_B1_MAIN = 3'd1,
    TGT_B1_AUX  = 3'd2,
    TGT_B2_MAIN = 3'd3,
    TGT_B2_AUX  = 3'd4
  } tgt_e;

  typedef struct packed {
    logic bank1;
    logic rd_en;
    logic wr_en;
    logic arm;
  } ovl_state_t;
endpackage

// File: rtl/hiram_switch_decode.sv
module hiram_switch_decode #(
  parameter int OFF_W     = 8,
  parameter int SW_NIBBLE = 8,
  parameter int ST_BANK   = 17,
  parameter int ST_READ   = 18
) (
  input  logic             strobe,
  input  logic [OFF_W-1:0] offset,
  input  logic             is_write,
  output logic             sw_hit,
  output logic             st_bank_hit,
  output logic             st_read_hit,
  output logic             bit_odd,
  output logic             bit_off,
  output logic             bit_bank1
);
  localparam int NIB_W = OFF_W - 4;

  always_comb begin
    sw_hit      = strobe && (offset[OFF_W-1:4] == NIB_W'(SW_NIBBLE));
    st_bank_hit = strobe && !is_write && (offset == OFF_W'(ST_BANK));
    st_read_hit = strobe && !is_write && (offset == OFF_W'(ST_READ));
    bit_odd     = offset[0];
    bit_off     = offset[1];
    bit_bank1   = offset[3];
  end
endmodule

// File: rtl/hiram_state.sv
module hiram_state
  import hiram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_hit,
  input  logic       is_write,
  input  logic       bit_odd,
  input  logic       bit_off,
  input  logic       bit_bank1,
  output ovl_state_t st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (sw_hit) begin
      st.bank1 <= bit_bank1;
      if (bit_odd) begin
        if (!is_write) st.wr_en <= st.arm;
        st.arm   <= !is_write;
        st.rd_en <= bit_off;
      end else begin
        st.wr_en <= 1'b0;
        st.arm   <= 1'b0;
        st.rd_en <= !bit_off;
      end
    end
  end

  assert_even_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hit && !bit_odd) |=> (!st.wr_en && !st.arm && (st.rd_en == !$past(bit_off))));

  assert_odd_read_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hit && bit_odd) |=> (st.rd_en == $past(bit_off)));

  assert_wen_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.wr_en) |-> ($past(st.arm) && $past(sw_hit) && $past(bit_odd) && !$past(is_write)));

  assert_write_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hit && bit_odd && is_write) |=> (!st.arm && $stable(st.wr_en)));

  assert_bank_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hit |=> (st.bank1 == $past(bit_bank1)));

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_hit |=> $stable(st));
endmodule

// File: rtl/hiram_page_map.sv
module hiram_page_map
  import hiram_pkg::*;
#(
  parameter int PAGE_W   = 8,
  parameter int OVL_LO   = 208,
  parameter int SHARE_LO = 224
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page,
  input  logic              path_en,
  input  logic              bank1,
  input  logic              aux,
  output logic              in_ovl,
  output tgt_e              tgt
);
  logic shared;

  always_comb begin
    in_ovl = (page >= PAGE_W'(OVL_LO));
    shared = (page >= PAGE_W'(SHARE_LO));
    tgt    = TGT_ROM;
    if (in_ovl && path_en) begin
      if (shared || bank1) tgt = aux ? TGT_B1_AUX : TGT_B1_MAIN;
      else                 tgt = aux ? TGT_B2_AUX : TGT_B2_MAIN;
    end
  end

  assert_rom_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en |-> (tgt == TGT_ROM));

  assert_low_pages_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ovl |-> (tgt == TGT_ROM));

  assert_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shared && path_en) |-> (tgt == TGT_B1_MAIN || tgt == TGT_B1_AUX));
endmodule

// File: rtl/hiram_overlay_ctrl.sv
module hiram_overlay_ctrl
  import hiram_pkg::*;
#(
  parameter int OFF_W     = 8,
  parameter int PAGE_W    = 8,
  parameter int SW_NIBBLE = 8,
  parameter int ST_BANK   = 17,
  parameter int ST_READ   = 18,
  parameter int OVL_LO    = 208,
  parameter int SHARE_LO  = 224,
  parameter int FLAG_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_strobe,
  input  logic [OFF_W-1:0]  io_offset,
  input  logic              io_write,
  input  logic              alt_zp,
  input  logic [PAGE_W-1:0] cpu_page,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              in_overlay,
  output logic [2:0]        rd_target,
  output logic [2:0]        wr_target
);
  localparam int NPATH = 2;
  localparam logic [7:0] FLAG = 8'(1 << FLAG_BIT);

  logic sw_hit, st_bank_hit, st_read_hit, bit_odd, bit_off, bit_bank1;
  ovl_state_t st;
  logic [NPATH-1:0] path_en;
  logic [NPATH-1:0] path_in;
  tgt_e             path_tgt [NPATH];

  hiram_switch_decode #(
    .OFF_W(OFF_W), .SW_NIBBLE(SW_NIBBLE), .ST_BANK(ST_BANK), .ST_READ(ST_READ)
  ) u_dec (
    .strobe(io_strobe), .offset(io_offset), .is_write(io_write),
    .sw_hit(sw_hit), .st_bank_hit(st_bank_hit), .st_read_hit(st_read_hit),
    .bit_odd(bit_odd), .bit_off(bit_off), .bit_bank1(bit_bank1)
  );

  hiram_state u_st (
    .clk(clk), .rst_n(rst_n), .sw_hit(sw_hit), .is_write(io_write),
    .bit_odd(bit_odd), .bit_off(bit_off), .bit_bank1(bit_bank1), .st(st)
  );

  assign path_en[0] = st.rd_en;
  assign path_en[1] = st.wr_en;

  for (genvar gi = 0; gi < NPATH; gi++) begin : g_path
    hiram_page_map #(.PAGE_W(PAGE_W), .OVL_LO(OVL_LO), .SHARE_LO(SHARE_LO)) u_map (
      .clk(clk), .rst_n(rst_n), .page(cpu_page), .path_en(path_en[gi]),
      .bank1(st.bank1), .aux(alt_zp), .in_ovl(path_in[gi]), .tgt(path_tgt[gi])
    );
  end

  assign in_overlay = path_in[0];
  assign rd_target  = path_tgt[0];
  assign wr_target  = path_tgt[1];

  always_comb begin
    io_rdata  = 8'h00;
    io_rvalid = 1'b0;
    if (st_bank_hit) begin
      io_rvalid = 1'b1;
      io_rdata  = st.bank1 ? 8'h00 : FLAG;
    end else if (st_read_hit) begin
      io_rvalid = 1'b1;
      io_rdata  = st.rd_en ? FLAG : 8'h00;
    end else if (sw_hit && !io_write) begin
      io_rvalid = 1'b1;
    end
  end

  assert_switch_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hit && !io_write) |-> (io_rvalid && io_rdata == 8'h00));

  assert_paths_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    path_in[0] == path_in[1]);
endmodule

// File: tb/test_hiram_overlay_ctrl.sv
module test_hiram_overlay_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_strobe = 1'b0;
  logic [7:0] io_offset = 8'h00;
  logic io_write = 1'b0;
  logic alt_zp = 1'b0;
  logic [7:0] cpu_page = 8'hD5;
  logic [7:0] io_rdata;
  logic io_rvalid, in_overlay;
  logic [2:0] rd_target, wr_target;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hiram_overlay_ctrl i_hiram_overlay_ctrl (
    .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_offset(io_offset),
    .io_write(io_write), .alt_zp(alt_zp), .cpu_page(cpu_page),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid), .in_overlay(in_overlay),
    .rd_target(rd_target), .wr_target(wr_target)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one access; read data is sampled while the strobe is high
  task automatic acc(input logic [7:0] off, input logic wr, output logic [7:0] rd, output logic rv);
    @(negedge clk);
    io_offset = off; io_write = wr; io_strobe = 1'b1;
    #1; rd = io_rdata; rv = io_rvalid;
    @(posedge clk);
    @(negedge clk);
    io_strobe = 1'b0; io_write = 1'b0;
    #1;
  endtask

  task automatic touch(input logic [7:0] off, input logic wr);
    logic [7:0] d; logic v;
    acc(off, wr, d, v);
  endtask

  task automatic look(input logic [7:0] pg, input logic az);
    cpu_page = pg; alt_zp = az; #1;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic v;
    look(8'hD5, 1'b0);
    chk("R10 rd", rd_target, 0);
    chk("R10 wr", wr_target, 0);
    acc(8'h11, 1'b0, d, v);
    chk("R10 bank2 status", d, 8'h80);
    acc(8'h12, 1'b0, d, v);
    chk("R10 rom read status", d, 8'h00);
  endtask

  task automatic t_read_modes;
    touch(8'h80, 1'b0); look(8'hD5, 1'b0);
    chk("R1 0x80 rd ram", rd_target, 3);
    chk("R1 0x80 wr off", wr_target, 0);
    touch(8'h82, 1'b0);
    chk("R1 0x82 rd rom", rd_target, 0);
    touch(8'h83, 1'b0);
    chk("R2 0x83 rd ram", rd_target, 3);
    touch(8'h81, 1'b0);
    chk("R2 0x81 rd rom", rd_target, 0);
  endtask

  task automatic t_prewrite;
    touch(8'h82, 1'b0); look(8'hD5, 1'b0);
    touch(8'h81, 1'b0);
    chk("R3 one read no wen", wr_target, 0);
    touch(8'h81, 1'b0);
    chk("R3 two reads wen", wr_target, 3);
    chk("R8 rd stays rom", rd_target, 0);
    touch(8'h80, 1'b0);
    chk("R1 even clears wen", wr_target, 0);
  endtask

  task automatic t_write_blocks;
    touch(8'h80, 1'b0); look(8'hD5, 1'b0);
    touch(8'h83, 1'b0); touch(8'h83, 1'b1); touch(8'h83, 1'b0);
    chk("R4 r-w-r no wen", wr_target, 0);
    touch(8'h83, 1'b0);
    chk("R3 next read wen", wr_target, 3);
    touch(8'h83, 1'b1);
    chk("R4 write keeps wen", wr_target, 3);
    touch(8'h80, 1'b0); touch(8'h81, 1'b1); touch(8'h81, 1'b1);
    chk("R4 two writes no wen", wr_target, 0);
  endtask

  task automatic t_banks;
    touch(8'h8B, 1'b0); touch(8'h8B, 1'b0);
    look(8'hD5, 1'b0); chk("R5 bank1 main rd", rd_target, 1);
    chk("R6 bank1 main wr", wr_target, 1);
    look(8'hD5, 1'b1); chk("R6 bank1 aux", rd_target, 2);
    look(8'hE3, 1'b1); chk("R7 shared aux", rd_target, 2);
    touch(8'h83, 1'b0);
    look(8'hDF, 1'b0); chk("R5 bank2 main", rd_target, 3);
    look(8'hD0, 1'b1); chk("R6 bank2 aux", rd_target, 4);
    look(8'hFF, 1'b0); chk("R7 shared main", rd_target, 1);
    look(8'hE0, 1'b1); chk("R7 shared aux wr", wr_target, 2);
  endtask

  task automatic t_status;
    logic [7:0] d; logic v;
    touch(8'h8B, 1'b0);
    acc(8'h11, 1'b0, d, v); chk("R9 bank1 status", d, 0);
    chk("R9 status valid", v, 1);
    acc(8'h12, 1'b0, d, v); chk("R9 ram read status", d, 8'h80);
    acc(8'h8B, 1'b0, d, v); chk("R9 switch read zero", d, 0);
    chk("R9 switch read valid", v, 1);
    acc(8'h82, 1'b0, d, v);
    acc(8'h11, 1'b0, d, v); chk("R9 bank2 status", d, 8'h80);
    acc(8'h12, 1'b0, d, v); chk("R9 rom status", d, 0);
  endtask

  task automatic t_outside;
    touch(8'h80, 1'b0); touch(8'h8B, 1'b0); touch(8'h8B, 1'b0);
    touch(8'h05, 1'b1); touch(8'h7F, 1'b0); touch(8'h90, 1'b0); touch(8'h12, 1'b1);
    look(8'hD5, 1'b0);
    chk("R11 rd kept", rd_target, 1);
    chk("R11 wr kept", wr_target, 1);
  endtask

  task automatic t_low_page;
    look(8'hCF, 1'b0);
    chk("R12 in_overlay", in_overlay, 0);
    chk("R12 rd", rd_target, 0);
    chk("R12 wr", wr_target, 0);
    look(8'hD0, 1'b0);
    chk("R12 edge in", in_overlay, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_modes();
    t_prewrite();
    t_write_blocks();
    t_banks();
    t_status();
    t_outside();
    t_low_page();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule